// File: doc/BRIEF.md
# Skewed Source Fetch Aligner

This unit supplies the source operand of a raster block-transfer engine. For each destination word the engine asks for, it reads zero, one or two 16-bit source words from memory, keeps them in a 32-bit window, and returns one 16-bit word cut from that window at a bit offset (the skew). The skew sets the bit alignment between source and destination. The unit tracks the source address inside a line, stepping by a signed x increment. Source lines can therefore be walked upward or downward in memory.

Each request to the unit is a step. A step carries strobes that mark the first and the last word of a line. Two control flags shape a line. The first flag adds a read before the first word, which primes the window. The second flag drops the read on the last word, so the window only shifts. With those flags the window also fills correctly when the increment is negative. The surrounding engine loads the start address of each line through the address-load port. It also applies any line-to-line address stride itself.

Top module: `skew_fetch_align`

## Requirements
- R1: While reset is asserted and after it is released, `step_ready` is 1 and `rd_req`, `word_valid` and `src_addr` are all 0.
- R2: The aligned word is bits [skew+15:skew] of the 32-bit window, where skew is `ctrl_byte[3:0]` taken at the step.
- R3: With `x_inc[15]` = 0 (upward), each step that fetches shifts the window left by 16 bits, and the word read for the step fills the low half.
- R4: With `x_inc[15]` = 1 (downward), each step that fetches shifts the window right by 16 bits, and the word read for the step fills the high half.
- R5: When `ctrl_byte[7]` = 1 on the first word of a line, an additional read at the current address comes first. Its data replaces the window, placed in the high half (upward) or the low half (downward), and the address then moves by one increment.
- R6: When `ctrl_byte[6]` = 1 on the last word of a line, that step makes no read of its own and the address moves back by one increment.
- R7: After every read made for a step, the address moves by one increment unless the step is the last word of its line. The address changes at no other time except through `addr_load`.
- R8: The window is cleared to zero when a step has `step_first` = 1.
- R9: When `opsel[1]` = 0 (operand select 0 or 1), a step makes no read, leaves the address unchanged, and returns `word_valid` on the next cycle.
- R10: `word_valid` is a one-cycle pulse raised only after every read of the step has been acknowledged. While a read is pending, `rd_req` stays high and `src_addr` stays stable.
- R11: `step_ready` is low from a step's acceptance until after its `word_valid`. Step requests made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_req | input | 1 | Request one aligned word; taken when `step_ready` is 1 |
| step_first | input | 1 | The step is the first word of a line |
| step_last | input | 1 | The step is the last word of a line |
| step_ready | output | 1 | Unit is idle and can accept a step |
| ctrl_byte | input | 8 | [7] extra first read, [6] no final read, [3:0] skew |
| opsel | input | 2 | Operand select; source is fetched when bit 1 is set |
| x_inc | input | 16 | Signed source x increment in address units |
| addr_load | input | 1 | Load `addr_in` into the source address while idle |
| addr_in | input | 24 | Start address for a line |
| rd_req | output | 1 | Memory read request at `src_addr` |
| rd_ack | input | 1 | Read data valid; completes the pending read |
| rd_data | input | 16 | Read data |
| word_valid | output | 1 | `word_out` holds the aligned word of the step |
| word_out | output | 16 | Aligned source word |
| src_addr | output | 24 | Current source address; also the read address |

## Verification
The extra first read and the no-final-read step-back can fall on the same acknowledge cycle. This happens on a line only one word long with both flags set: the read advances the address and the step-back undoes it in that cycle. The bench runs that case and expects exactly one read. It also expects the address to end where it started, and the word to come from the high half of the window after the skew. A second overlap comes from a memory stall held across a step. It puts a pending read together with a fresh step request, and the bench checks that the request is ignored and only one word is returned.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  // Control byte field positions decoded by the aligner
  localparam int CTRL_EXTRA_BIT   = 7;
  localparam int CTRL_NOFINAL_BIT = 6;
  localparam int CTRL_SKEW_LSB    = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXTRA = 2'd1,
    ST_MAIN  = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  typedef enum logic [2:0] {
    BUF_HOLD   = 3'd0,
    BUF_CLEAR  = 3'd1,
    BUF_SHIFT  = 3'd2,
    BUF_LOAD_X = 3'd3,
    BUF_LOAD_M = 3'd4
  } buf_op_e;

endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
  import sfa_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int INC_W  = 16,
  parameter int SKEW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_req,
  input  logic              step_first,
  input  logic              step_last,
  input  logic              extra_in,
  input  logic              nofinal_in,
  input  logic              fetch_in,
  input  logic [SKEW_W-1:0] skew_in,
  input  logic [INC_W-1:0]  x_inc,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_ack,
  output logic              step_ready,
  output logic              rd_req,
  output logic              word_valid,
  output logic [ADDR_W-1:0] src_addr,
  output buf_op_e           buf_op,
  output logic              desc,
  output logic [SKEW_W-1:0] skew_q
);

  localparam int EXT_W = ADDR_W - INC_W;

  state_e              state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   inc_q;
  logic [ADDR_W-1:0]   inc_ext;
  logic                last_q, nofinal_q, desc_q;
  logic                accept;

  assign inc_ext = {{EXT_W{x_inc[INC_W-1]}}, x_inc};
  assign accept  = (state_q == ST_IDLE) && step_req;

  // Next-state and address logic
  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    buf_op     = BUF_HOLD;
    rd_req     = 1'b0;
    word_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (step_req) begin
          if (step_first)      buf_op = BUF_CLEAR;
          else if (fetch_in)   buf_op = BUF_SHIFT;
          if (!fetch_in) begin
            state_d = ST_DONE;
          end else if (step_first && extra_in) begin
            state_d = ST_EXTRA;
          end else if (step_last && nofinal_in) begin
            addr_d  = addr_q - inc_ext;
            state_d = ST_DONE;
          end else begin
            state_d = ST_MAIN;
          end
        end else if (addr_load) begin
          addr_d = addr_in;
        end
      end
      ST_EXTRA: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          buf_op = BUF_LOAD_X;
          if (last_q && nofinal_q) begin
            state_d = ST_DONE;
          end else begin
            addr_d  = addr_q + inc_q;
            state_d = ST_MAIN;
          end
        end
      end
      ST_MAIN: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          buf_op  = BUF_LOAD_M;
          if (!last_q) addr_d = addr_q + inc_q;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        word_valid = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State and address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  // Step parameters captured at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q     <= '0;
      last_q    <= 1'b0;
      nofinal_q <= 1'b0;
      desc_q    <= 1'b0;
      skew_q    <= '0;
    end else if (accept) begin
      inc_q     <= inc_ext;
      last_q    <= step_last;
      nofinal_q <= nofinal_in;
      desc_q    <= x_inc[INC_W-1];
      skew_q    <= skew_in;
    end
  end

  assign step_ready = (state_q == ST_IDLE);
  assign src_addr   = addr_q;
  assign desc       = (state_q == ST_IDLE) ? x_inc[INC_W-1] : desc_q;

endmodule

// File: rtl/sfa_buffer.sv
module sfa_buffer
  import sfa_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  buf_op_e             buf_op,
  input  logic                desc,
  input  logic [WORD_W-1:0]   rd_data,
  output logic [2*WORD_W-1:0] window
);

  localparam int BUF_W = 2 * WORD_W;

  logic [BUF_W-1:0] win_q, win_d;
  logic             win_en;

  always_comb begin
    win_d  = win_q;
    win_en = 1'b1;
    unique case (buf_op)
      BUF_CLEAR:  win_d = '0;
      BUF_SHIFT:  win_d = desc ? {{WORD_W{1'b0}}, win_q[BUF_W-1:WORD_W]}
                               : {win_q[WORD_W-1:0], {WORD_W{1'b0}}};
      BUF_LOAD_X: win_d = desc ? {{WORD_W{1'b0}}, rd_data}
                               : {rd_data, {WORD_W{1'b0}}};
      BUF_LOAD_M: win_d = desc ? {rd_data, win_q[WORD_W-1:0]}
                               : {win_q[BUF_W-1:WORD_W], rd_data};
      default:    win_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign window = win_q;

endmodule

// File: rtl/sfa_skew.sv
module sfa_skew #(
  parameter int WORD_W = 16,
  parameter int SKEW_W = 4
) (
  input  logic [2*WORD_W-1:0] window,
  input  logic [SKEW_W-1:0]   skew,
  output logic [WORD_W-1:0]   word
);

  localparam int SEL_N = 1 << SKEW_W;

  logic [WORD_W-1:0] cand [SEL_N];

  for (genvar s = 0; s < SEL_N; s++) begin : g_tap
    assign cand[s] = window[s +: WORD_W];
  end

  assign word = cand[skew];

endmodule

// File: rtl/skew_fetch_align.sv
module skew_fetch_align
  import sfa_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 24,
  parameter int INC_W  = 16,
  parameter int SKEW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_req,
  input  logic              step_first,
  input  logic              step_last,
  output logic              step_ready,
  input  logic [7:0]        ctrl_byte,
  input  logic [1:0]        opsel,
  input  logic [INC_W-1:0]  x_inc,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] rd_data,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic [ADDR_W-1:0] src_addr
);

  localparam int BUF_W = 2 * WORD_W;

  logic              extra_flag, nofinal_flag, fetch_en;
  logic [SKEW_W-1:0] skew_raw, skew_held;
  buf_op_e           buf_op;
  logic              desc;
  logic [BUF_W-1:0]  window;

  assign extra_flag   = ctrl_byte[CTRL_EXTRA_BIT];
  assign nofinal_flag = ctrl_byte[CTRL_NOFINAL_BIT];
  assign skew_raw     = ctrl_byte[CTRL_SKEW_LSB +: SKEW_W];
  assign fetch_en     = opsel[1];

  sfa_ctrl #(
    .ADDR_W (ADDR_W),
    .INC_W  (INC_W),
    .SKEW_W (SKEW_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_req   (step_req),
    .step_first (step_first),
    .step_last  (step_last),
    .extra_in   (extra_flag),
    .nofinal_in (nofinal_flag),
    .fetch_in   (fetch_en),
    .skew_in    (skew_raw),
    .x_inc      (x_inc),
    .addr_load  (addr_load),
    .addr_in    (addr_in),
    .rd_ack     (rd_ack),
    .step_ready (step_ready),
    .rd_req     (rd_req),
    .word_valid (word_valid),
    .src_addr   (src_addr),
    .buf_op     (buf_op),
    .desc       (desc),
    .skew_q     (skew_held)
  );

  sfa_buffer #(
    .WORD_W (WORD_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .buf_op  (buf_op),
    .desc    (desc),
    .rd_data (rd_data),
    .window  (window)
  );

  sfa_skew #(
    .WORD_W (WORD_W),
    .SKEW_W (SKEW_W)
  ) u_skew (
    .window (window),
    .skew   (skew_held),
    .word   (word_out)
  );

endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_req,
  input logic              step_ready,
  input logic [1:0]        opsel,
  input logic              addr_load,
  input logic              rd_req,
  input logic              rd_ack,
  input logic              word_valid,
  input logic [ADDR_W-1:0] src_addr
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(src_addr))); // R10

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R10

  AST_BUSY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !step_ready); // R11

  AST_NOFETCH_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ready && step_req && !opsel[1]) |=> (!rd_req && word_valid)); // R9

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ack && !addr_load && !(step_ready && step_req)) |=> $stable(src_addr)); // R7

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> !rd_req); // R10

endmodule

bind skew_fetch_align sfa_checker #(
  .WORD_W (WORD_W),
  .ADDR_W (ADDR_W)
) u_sfa_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_req   (step_req),
  .step_ready (step_ready),
  .opsel      (opsel),
  .addr_load  (addr_load),
  .rd_req     (rd_req),
  .rd_ack     (rd_ack),
  .word_valid (word_valid),
  .src_addr   (src_addr)
);

// File: tb/tb_skew_fetch_align.sv
module tb_skew_fetch_align;

  logic        clk, rst_n;
  logic        step_req, step_first, step_last, step_ready;
  logic [7:0]  ctrl_byte;
  logic [1:0]  opsel;
  logic [15:0] x_inc;
  logic        addr_load;
  logic [23:0] addr_in;
  logic        rd_req, rd_ack;
  logic [15:0] rd_data;
  logic        word_valid;
  logic [15:0] word_out;
  logic [23:0] src_addr;
  logic        stall;
  int          checks, errors, rd_count;
  logic        done;

  skew_fetch_align dut (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_first(step_first),
    .step_last(step_last), .step_ready(step_ready), .ctrl_byte(ctrl_byte),
    .opsel(opsel), .x_inc(x_inc), .addr_load(addr_load), .addr_in(addr_in),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .word_valid(word_valid), .word_out(word_out), .src_addr(src_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] memval(input logic [23:0] a);
    logic [15:0] t;
    t = {10'h0, a[6:1]} * 16'h2D1B;
    return t ^ 16'hA55A;
  endfunction

  // Memory model: one-cycle acknowledge, optional stall
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack   <= 1'b0;
      rd_data  <= '0;
      rd_count <= 0;
    end else begin
      rd_ack  <= rd_req && !rd_ack && !stall;
      rd_data <= memval(src_addr);
      if (rd_req && rd_ack) rd_count <= rd_count + 1;
    end
  end

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [1:0]  op;
    logic [15:0] inc;
    logic [23:0] start;
    logic [7:0]  n;
    logic [23:0] exp_addr;
    logic [7:0]  exp_reads;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 2'd2, 16'h0002, 24'h10, 8'd4, 24'h16, 8'd4},
    '{8'h85, 2'd3, 16'h0002, 24'h10, 8'd4, 24'h18, 8'd5},
    '{8'hC9, 2'd2, 16'h0002, 24'h10, 8'd4, 24'h16, 8'd4},
    '{8'h4F, 2'd2, 16'h0002, 24'h10, 8'd4, 24'h14, 8'd3},
    '{8'h83, 2'd2, 16'hFFFE, 24'h30, 8'd3, 24'h2A, 8'd4},
    '{8'h07, 2'd3, 16'hFFFE, 24'h40, 8'd3, 24'h3C, 8'd3},
    '{8'h4C, 2'd2, 16'hFFFE, 24'h40, 8'd3, 24'h3E, 8'd2},
    '{8'hC4, 2'd2, 16'h0002, 24'h20, 8'd1, 24'h20, 8'd1},
    '{8'h85, 2'd1, 16'h0002, 24'h20, 8'd3, 24'h20, 8'd0},
    '{8'hC2, 2'd0, 16'hFFFE, 24'h20, 8'd2, 24'h20, 8'd0},
    '{8'h0A, 2'd2, 16'h0002, 24'h20, 8'd1, 24'h20, 8'd1},
    '{8'h81, 2'd2, 16'h0004, 24'h00, 8'd3, 24'h0C, 8'd4}
  };

  logic [15:0] exp_words [16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of one line, from the requirements
  task automatic model_line(input vec_t v, output logic [23:0] a_end, output int nr);
    logic [31:0] b;
    logic [23:0] a, ie;
    logic        dn;
    b  = '0;
    a  = v.start;
    ie = {{8{v.inc[15]}}, v.inc};
    dn = v.inc[15];
    nr = 0;
    for (int w = 0; w < int'(v.n); w++) begin
      logic fst, lst;
      fst = (w == 0);
      lst = (w == int'(v.n) - 1);
      if (fst) b = '0;
      if (v.op[1]) begin
        if (fst && v.ctrl[7]) begin
          b = dn ? {16'h0, memval(a)} : {memval(a), 16'h0};
          a = a + ie;
          nr++;
        end else begin
          b = dn ? (b >> 16) : (b << 16);
        end
        if (lst && v.ctrl[6]) begin
          a = a - ie;
        end else begin
          if (dn) b[31:16] = memval(a);
          else    b[15:0]  = memval(a);
          nr++;
          if (!lst) a = a + ie;
        end
      end
      exp_words[w] = 16'(b >> v.ctrl[3:0]);
    end
    a_end = a;
  endtask

  task automatic load_addr(input logic [23:0] a);
    @(negedge clk);
    addr_load = 1'b1;
    addr_in   = a;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic run_line(input vec_t v);
    logic [23:0] a_end;
    int          nr, rd0;
    model_line(v, a_end, nr);
    ctrl_byte = v.ctrl;
    opsel     = v.op;
    x_inc     = v.inc;
    load_addr(v.start);
    rd0 = rd_count;
    for (int w = 0; w < int'(v.n); w++) begin
      step_req   = 1'b1;
      step_first = (w == 0);
      step_last  = (w == int'(v.n) - 1);
      @(negedge clk);
      step_req = 1'b0;
      while (!word_valid) @(negedge clk);
      check("R2 R3 R4 R5 R6 R8 word", {16'h0, word_out}, {16'h0, exp_words[w]});
      @(negedge clk);
      check("R10 valid pulse", {31'h0, word_valid}, 32'h0);
    end
    check("R5 R6 R7 addr", {8'h0, src_addr}, {8'h0, v.exp_addr});
    check("R7 model addr", {8'h0, src_addr}, {8'h0, a_end});
    check("R5 R6 R9 reads", rd_count - rd0, {24'h0, v.exp_reads});
    check("R9 model reads", rd_count - rd0, nr);
  endtask

  task automatic finish_sim();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  initial begin
    int vc;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; step_req = 1'b0; step_first = 1'b0; step_last = 1'b0;
    ctrl_byte = '0; opsel = '0; x_inc = '0; addr_load = 1'b0; addr_in = '0;
    stall = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'h0, step_ready}, 32'h1);
    check("R1 rd_req in reset", {31'h0, rd_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'h0, word_valid}, 32'h0);
    check("R1 addr after reset", {8'h0, src_addr}, 32'h0);

    for (int i = 0; i < NV; i++) run_line(VECS[i]);

    // R10 / R11: stalled read with a step request during it
    ctrl_byte = 8'h00; opsel = 2'd2; x_inc = 16'h0002;
    load_addr(24'h08);
    stall = 1'b1;
    step_req = 1'b1; step_first = 1'b1; step_last = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 req held in stall", {31'h0, rd_req}, 32'h1);
    check("R10 no valid in stall", {31'h0, word_valid}, 32'h0);
    check("R10 addr stable in stall", {8'h0, src_addr}, 32'h08);
    check("R11 busy in stall", {31'h0, step_ready}, 32'h0);
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    stall = 1'b0;
    while (!word_valid) @(negedge clk);
    check("R2 R3 stalled word", {16'h0, word_out}, {16'h0, memval(24'h08)});
    vc = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (word_valid) vc++;
    end
    check("R11 ignored busy step", vc, 0);
    check("R11 ready after step", {31'h0, step_ready}, 32'h1);

    done = 1'b1;
    finish_sim();
  end

endmodule